// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Tracker

This block follows the clock-enable behaviour of a four-bank synchronous DRAM from the controller side. On every rising clock edge it takes the clock-enable level, the four active-low command pins (chip select, row strobe, column strobe, write enable) and a flag from the bank logic that says every bank is idle. It keeps the clock-enable level of the previous edge internally. From the pair of clock-enable values at edges n-1 and n, together with the command and the bank flag, it works out which power state the memory is in: idle, active (normal operation), self-refresh, self-refresh recovery, power-down or clock suspend.

The tracker is meant to sit next to a memory controller or a memory model. It reports the present state, says whether ordinary commands may be issued, and raises a sticky error when a sequence breaks the clock-enable rules. The sequences it checks are a low-power entry with a bank still open, a non-idle command while the memory wakes up, and clock-enable dropping during recovery. After self-refresh ends, the state stays in recovery for a programmable row-cycle time. A separate, programmable exit guard keeps ordinary commands illegal for a number of cycles after the wake-up edge. The full command decoder, bank timing and data path are outside this block.

Top module: `sdram_cke_tracker`

## Requirements
- R1: On a synchronous active-high reset the state is idle (code 0), the command-accept flag is 1, the error flag is 0, and the stored previous clock-enable is taken as high.
- R2: With clock-enable high at both n-1 and n in idle or active, the next state is idle (code 0) when all banks are idle and active (code 1) otherwise. The command-accept flag is then 1 unless the exit guard of R6 is running.
- R3: In idle or active, clock-enable high at n-1 and low at n with a refresh command (cs_n=0, ras_n=0, cas_n=0, we_n=1) and all banks idle enters self-refresh (code 2). Clock-enable low at both n-1 and n keeps self-refresh.
- R4: In self-refresh, clock-enable low at n-1 and high at n moves to self-refresh recovery (code 3). The state stays in recovery for exactly TRC observed cycles and then reads idle.
- R5: During recovery, any command other than a deselect (cs_n=1) or a no-operation (cs_n=0, ras_n=1, cas_n=1, we_n=1) sets the error flag, and so does clock-enable low. Deselect and no-operation with clock-enable high leave the flag clear.
- R6: For TSREX cycles after the self-refresh exit edge, any command other than deselect or no-operation sets the error flag, even when the state already reads idle. From the next cycle on, such commands are legal.
- R7: In idle, clock-enable falling (high at n-1, low at n) with a deselect or no-operation and all banks idle enters power-down (code 4). Low at both edges holds it. Low at n-1 and high at n returns to idle on the next cycle.
- R8: With a bank open (all-idle flag 0), clock-enable falling with any command other than refresh enters clock suspend (code 5) on the next cycle. Clock-enable held low keeps it, and clock-enable returning high leaves it on the next cycle to active, or to idle if the banks have meanwhile gone idle.
- R9: A low-power entry that breaks the rules sets the error flag. A refresh with a falling clock-enable while a bank is open goes to clock suspend and raises the error. Any command other than deselect, no-operation or refresh with a falling clock-enable while all banks are idle keeps the state idle and raises the error.
- R10: The wake-up cycle out of self-refresh or power-down (clock-enable low at n-1, high at n) must carry a deselect or no-operation; any other command sets the error flag.
- R11: The error flag stays set through all later cycles until reset.
- R12: The command-accept flag is 1 only in idle or active with clock-enable high and no running exit guard. It is 0 in every low-power, suspend and recovery state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock-enable level sampled at this edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| banks_idle | input | 1 | High when every bank is precharged and idle |
| mode | output | 3 | Power state: 0 idle, 1 active, 2 self-refresh, 3 recovery, 4 power-down, 5 clock suspend |
| cmd_ok | output | 1 | Ordinary commands may be issued |
| illegal_err | output | 1 | Sticky illegal-sequence flag |

## Verification
All sixteen command codes are swept with a falling clock-enable, both with every bank idle and with a bank open. This separates the self-refresh, power-down, clock-suspend and illegal branches from one another. The wake-up cycles out of self-refresh and power-down are tried with a quiet command and with an active command, which shows that the wake-up check is separate from the transition itself. Recovery is walked cycle by cycle against the row-cycle and exit-guard counts, with an active command placed on the last guarded cycle and on the first free one, so that an off-by-one in either counter is reported. Clock suspend is held and released with the bank flag set both ways, and an error is followed by quiet cycles and then a reset to show that the flag is sticky.

// File: rtl/cke_tracker_pkg.sv
package cke_tracker_pkg;

  typedef enum logic [2:0] {
    PS_IDLE    = 3'd0,
    PS_ACTIVE  = 3'd1,
    PS_SELFREF = 3'd2,
    PS_SRRECOV = 3'd3,
    PS_PWRDN   = 3'd4,
    PS_SUSPEND = 3'd5
  } pstate_t;

  function automatic logic is_awake(input pstate_t s);
    return (s == PS_IDLE) || (s == PS_ACTIVE);
  endfunction

endpackage

// File: rtl/cke_cmd_decode.sv
module cke_cmd_decode (
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic quiet,
  output logic refresh
);
  logic nop;

  always_comb begin
    nop     = !cs_n && ras_n && cas_n && we_n;
    quiet   = cs_n || nop;
    refresh = !cs_n && !ras_n && !cas_n && we_n;
  end
endmodule

// File: rtl/cke_window_counter.sv
module cke_window_counter #(
  parameter int LOAD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy,
  output logic busy_nxt
);
  localparam int W = (LOAD < 1) ? 1 : $clog2(LOAD + 1);
  localparam logic [W-1:0] LOAD_V = W'(LOAD);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    if (load)
      cnt_d = LOAD_V;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = '0;
    busy     = (cnt_q != '0);
    busy_nxt = (cnt_d != '0);
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cke_mode_fsm.sv
module cke_mode_fsm
  import cke_tracker_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cke,
  input  logic    quiet,
  input  logic    refresh,
  input  logic    banks_idle,
  input  logic    rc_busy,
  input  logic    rc_busy_nxt,
  input  logic    guard_busy,
  input  logic    guard_busy_nxt,
  output logic    sr_exit,
  output pstate_t mode_q,
  output logic    cmd_ok_q,
  output logic    err_q
);
  pstate_t nxt;
  pstate_t awake_nxt;
  logic    cke_prev_q;
  logic    bad;
  logic    cke_fall;
  logic    cke_rise;
  logic    cmd_ok_d;

  always_comb begin
    cke_fall  = cke_prev_q && !cke;
    cke_rise  = !cke_prev_q && cke;
    awake_nxt = banks_idle ? PS_IDLE : PS_ACTIVE;
    nxt       = mode_q;
    bad       = guard_busy && !quiet;
    sr_exit   = 1'b0;
    unique case (mode_q)
      PS_IDLE, PS_ACTIVE: begin
        if (cke_fall) begin
          if (refresh) begin
            if (banks_idle) begin
              nxt = PS_SELFREF;
            end else begin
              nxt = PS_SUSPEND;
              bad = 1'b1;
            end
          end else if (!banks_idle) begin
            nxt = PS_SUSPEND;
          end else if (quiet) begin
            nxt = PS_PWRDN;
          end else begin
            nxt = PS_IDLE;
            bad = 1'b1;
          end
        end else begin
          nxt = awake_nxt;
        end
      end
      PS_SELFREF: begin
        if (cke_rise) begin
          nxt     = PS_SRRECOV;
          sr_exit = 1'b1;
          if (!quiet) bad = 1'b1;
        end
      end
      PS_SRRECOV: begin
        if (!cke || !quiet) bad = 1'b1;
        if (!rc_busy || !rc_busy_nxt) nxt = PS_IDLE;
      end
      PS_PWRDN: begin
        if (cke_rise) begin
          nxt = PS_IDLE;
          if (!quiet) bad = 1'b1;
        end
      end
      PS_SUSPEND: begin
        if (cke) nxt = awake_nxt;
      end
      default: nxt = PS_IDLE;
    endcase
    cmd_ok_d = is_awake(nxt) && cke && !guard_busy_nxt && !rc_busy_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= PS_IDLE;
      cke_prev_q <= 1'b1;
      err_q      <= 1'b0;
      cmd_ok_q   <= 1'b1;
    end else begin
      mode_q     <= nxt;
      cke_prev_q <= cke;
      err_q      <= err_q || bad;
      cmd_ok_q   <= cmd_ok_d;
    end
  end
endmodule

// File: rtl/sdram_cke_tracker.sv
module sdram_cke_tracker
  import cke_tracker_pkg::*;
#(
  parameter int TRC   = 4,
  parameter int TSREX = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       banks_idle,
  output logic [2:0] mode,
  output logic       cmd_ok,
  output logic       illegal_err
);
  logic    quiet;
  logic    refresh;
  logic    sr_exit;
  logic    rc_busy;
  logic    rc_busy_nxt;
  logic    guard_busy;
  logic    guard_busy_nxt;
  pstate_t mode_q;

  cke_cmd_decode u_dec (
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .quiet   (quiet),
    .refresh (refresh)
  );

  cke_window_counter #(.LOAD(TRC)) u_rc_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (sr_exit),
    .busy     (rc_busy),
    .busy_nxt (rc_busy_nxt)
  );

  cke_window_counter #(.LOAD(TSREX)) u_exit_guard (
    .clk      (clk),
    .rst      (rst),
    .load     (sr_exit),
    .busy     (guard_busy),
    .busy_nxt (guard_busy_nxt)
  );

  cke_mode_fsm u_fsm (
    .clk            (clk),
    .rst            (rst),
    .cke            (cke),
    .quiet          (quiet),
    .refresh        (refresh),
    .banks_idle     (banks_idle),
    .rc_busy        (rc_busy),
    .rc_busy_nxt    (rc_busy_nxt),
    .guard_busy     (guard_busy),
    .guard_busy_nxt (guard_busy_nxt),
    .sr_exit        (sr_exit),
    .mode_q         (mode_q),
    .cmd_ok_q       (cmd_ok),
    .err_q          (illegal_err)
  );

  assign mode = mode_q;
endmodule

// File: rtl/sdram_cke_tracker_chk.sv
module sdram_cke_tracker_chk #(
  parameter int TRC = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       cke,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic [2:0] mode,
  input logic       cmd_ok,
  input logic       illegal_err
);
  logic quiet_cmd;
  int   recov_run;

  assign quiet_cmd = cs_n || (ras_n && cas_n && we_n);

  always_ff @(posedge clk) begin
    if (rst)
      recov_run <= 0;
    else if (mode == 3'd3)
      recov_run <= recov_run + 1;
    else
      recov_run <= 0;
  end

  assert_sr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd2 && !cke) |=> (mode == 3'd2));

  assert_sr_exit_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd2 && cke) |=> (mode == 3'd3));

  assert_recov_len_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd3) |-> (recov_run < TRC));

  assert_recov_cmd_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd3 && !quiet_cmd) |=> illegal_err);

  assert_pd_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd4 && !cke) |=> (mode == 3'd4));

  assert_pd_exit_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd4 && cke) |=> (mode == 3'd0));

  assert_susp_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd5 && !cke) |=> (mode == 3'd5));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    illegal_err |=> illegal_err);

  assert_cmd_ok_R12: assert property (@(posedge clk) disable iff (rst)
    cmd_ok |-> (mode == 3'd0 || mode == 3'd1));
endmodule

bind sdram_cke_tracker sdram_cke_tracker_chk #(.TRC(TRC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cke         (cke),
  .cs_n        (cs_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .mode        (mode),
  .cmd_ok      (cmd_ok),
  .illegal_err (illegal_err)
);

// File: tb/sdram_cke_tracker_test.sv
`timescale 1ns/1ps
module sdram_cke_tracker_test;
  localparam int TRC   = 3;
  localparam int TSREX = 5;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_DES = 4'b1111;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_ACT = 4'b0011;

  localparam int M_IDLE = 0, M_ACT = 1, M_SR = 2, M_REC = 3, M_PD = 4, M_SUS = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cke = 1'b1;
  logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic       banks_idle = 1'b1;
  logic [2:0] mode;
  logic       cmd_ok;
  logic       illegal_err;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  sdram_cke_tracker #(.TRC(TRC), .TSREX(TSREX)) uut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .banks_idle(banks_idle),
    .mode(mode), .cmd_ok(cmd_ok), .illegal_err(illegal_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic [3:0] cmd, input logic bi);
    cke = c;
    {cs_n, ras_n, cas_n, we_n} = cmd;
    banks_idle = bi;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(1'b1, C_NOP, 1'b1);
    rst = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // enter self-refresh then leave it with a quiet wake-up cycle
  task automatic sr_cycle_out();
    step(1'b1, C_NOP, 1'b1);
    step(1'b0, C_REF, 1'b1);
    step(1'b0, C_DES, 1'b1);
    step(1'b1, C_NOP, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_up();
  end

  initial begin
    #1;
    do_reset();
    check("R1 mode", mode, M_IDLE);
    check("R1 cmd_ok", cmd_ok, 1);
    check("R1 err", illegal_err, 0);

    // R2: both edges high, state follows bank flag
    step(1'b1, C_ACT, 1'b0);
    check("R2 active", mode, M_ACT);
    check("R2 cmd_ok", cmd_ok, 1);
    step(1'b1, C_NOP, 1'b1);
    check("R2 idle", mode, M_IDLE);

    // R3 R7 R8 R9: sweep every command with a falling clock-enable
    for (int bi = 0; bi < 2; bi++) begin
      for (int cmd = 0; cmd < 16; cmd++) begin
        logic [3:0] cv;
        bit q, r;
        int em, ee;
        cv = 4'(cmd);
        q = cv[3] || (cv == C_NOP);
        r = (cv == C_REF);
        if (r) begin em = (bi != 0) ? M_SR : M_SUS; ee = (bi != 0) ? 0 : 1; end
        else if (bi == 0) begin em = M_SUS; ee = 0; end
        else if (q) begin em = M_PD; ee = 0; end
        else begin em = M_IDLE; ee = 1; end
        do_reset();
        step(1'b1, C_NOP, 1'(bi));
        step(1'b0, cv, 1'(bi));
        check("R3/R7/R8/R9 sweep mode", mode, em);
        check("R9 sweep err", illegal_err, ee);
        check("R12 sweep cmd_ok", cmd_ok, 0);
      end
    end

    // R3 R4 R12: self-refresh hold and recovery length
    do_reset();
    step(1'b1, C_NOP, 1'b1);
    step(1'b0, C_REF, 1'b1);
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 4'(k * 5), 1'b1);
      check("R3 hold", mode, M_SR);
    end
    step(1'b1, C_NOP, 1'b1);
    check("R4 enter recovery", mode, M_REC);
    check("R12 recovery cmd_ok", cmd_ok, 0);
    for (int j = 1; j <= TSREX + 1; j++) begin
      step(1'b1, (j % 2 == 0) ? C_DES : C_NOP, 1'b1);
      check("R4 recovery timeline", mode, (j >= TRC) ? M_IDLE : M_REC);
      check("R12 guard cmd_ok", cmd_ok, (j >= TRC && j >= TSREX) ? 1 : 0);
    end
    check("R5 quiet recovery no err", illegal_err, 0);

    // R5: active command inside recovery
    do_reset();
    sr_cycle_out();
    step(1'b1, C_ACT, 1'b1);
    check("R5 cmd in recovery", illegal_err, 1);

    // R5: clock-enable low during recovery
    do_reset();
    sr_cycle_out();
    step(1'b0, C_NOP, 1'b1);
    check("R5 cke low in recovery", illegal_err, 1);

    // R6: last guarded cycle and first free cycle
    do_reset();
    sr_cycle_out();
    for (int j = 1; j < TSREX; j++) step(1'b1, C_NOP, 1'b1);
    check("R6 idle before guard end", mode, M_IDLE);
    step(1'b1, C_ACT, 1'b1);
    check("R6 guarded cmd", illegal_err, 1);
    do_reset();
    sr_cycle_out();
    for (int j = 1; j <= TSREX; j++) step(1'b1, C_NOP, 1'b1);
    step(1'b1, C_ACT, 1'b1);
    check("R6 cmd after guard", illegal_err, 0);

    // R10: wake-up from self-refresh with a non-quiet command
    do_reset();
    step(1'b1, C_NOP, 1'b1);
    step(1'b0, C_REF, 1'b1);
    step(1'b1, C_ACT, 1'b1);
    check("R10 sr wake mode", mode, M_REC);
    check("R10 sr wake err", illegal_err, 1);

    // R7: power-down hold and exit
    do_reset();
    step(1'b1, C_NOP, 1'b1);
    step(1'b0, C_DES, 1'b1);
    step(1'b0, C_ACT, 1'b1);
    check("R7 pd hold", mode, M_PD);
    step(1'b1, C_NOP, 1'b1);
    check("R7 pd exit", mode, M_IDLE);
    check("R7 pd exit err", illegal_err, 0);
    check("R12 pd exit cmd_ok", cmd_ok, 1);

    // R10: power-down wake-up with active command
    do_reset();
    step(1'b1, C_NOP, 1'b1);
    step(1'b0, C_NOP, 1'b1);
    step(1'b1, C_ACT, 1'b1);
    check("R10 pd wake mode", mode, M_IDLE);
    check("R10 pd wake err", illegal_err, 1);

    // R11: error stays through quiet cycles, reset clears
    for (int k = 0; k < 4; k++) step(1'b1, C_NOP, 1'b1);
    check("R11 sticky", illegal_err, 1);
    do_reset();
    check("R11 reset clears", illegal_err, 0);

    // R8: clock suspend hold and release both ways
    step(1'b1, C_ACT, 1'b0);
    step(1'b0, C_NOP, 1'b0);
    check("R8 suspend start", mode, M_SUS);
    step(1'b0, C_ACT, 1'b0);
    step(1'b0, C_NOP, 1'b0);
    check("R8 suspend hold", mode, M_SUS);
    step(1'b1, C_NOP, 1'b0);
    check("R8 release active", mode, M_ACT);
    step(1'b0, C_NOP, 1'b0);
    step(1'b1, C_NOP, 1'b1);
    check("R8 release idle", mode, M_IDLE);
    check("R8 err", illegal_err, 0);

    finish_up();
  end
endmodule